// File: doc/BRIEF.md
# Fieldbus Receive Frame Stripper

This block sits between a fieldbus symbol decoder and the byte stream that feeds a host UART transmitter. The decoder hands it one tagged byte at a time, strobed by `in_valid_i`. Each byte is marked as a preamble, a start delimiter, a data byte, an end delimiter or a decode error. Only the payload bytes of a well-formed packet are passed on. Framing bytes are consumed, so the host sees just the data, starting with the first data byte.

While a packet is in flight, `receiving_o` stays high. The transmit path uses it to keep the half-duplex link to one direction at a time. No explicit end marker is given to the host. Instead, a gap timer counts microsecond ticks from the most recent byte. When 512 ticks pass with no byte, it emits a single-cycle `eop_o` pulse.

Payload bytes leave through a valid/ready port backed by a one-byte skid register. If a second data byte arrives while that register is still full and not being drained, the byte is lost and a sticky overflow flag is raised.

Top module: `fb_rx_stripper`

## Requirements
- R1: After reset, `out_valid_o`, `receiving_o`, `eop_o` and `overflow_o` are all low.
- R2: While idle, a byte tagged preamble (tag 0) raises `receiving_o` on the next clock. `receiving_o` stays high across further preambles.
- R3: Preamble and start delimiter (tag 1) bytes are never forwarded. After a start delimiter, each data byte (tag 2) appears on `out_data_o` with `out_valid_o` high one clock after it is strobed, in arrival order.
- R4: During payload, an end delimiter (tag 3) or any tag other than data lowers `receiving_o` on the next clock and is not forwarded.
- R5: A decode error (tag 4, and reserved tags 5 to 7 alike) lowers `receiving_o`. Data bytes that follow it are discarded until a new preamble and start delimiter arrive.
- R6: A data byte that follows preambles but comes before a start delimiter is discarded. The block returns to idle (`receiving_o` low), and a start delimiter seen while idle is also ignored.
- R7: While idle, bytes with tags other than preamble change no output.
- R8: Once a packet has begun, every byte restarts the gap count. The 512th microsecond tick with no byte since the last one produces `eop_o` high for exactly one clock, and `receiving_o` falls at that same edge if it was still high. The pulse also fires after a packet that closed with an end delimiter.
- R9: With `out_ready_i` low, `out_valid_o` and `out_data_o` hold steady. A data byte arriving while the output register is full and not drained is dropped and sets `overflow_o`. A new preamble while idle clears `overflow_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-cycle strobe per microsecond |
| in_valid_i | input | 1 | Tagged byte strobe from decoder |
| in_tag_i | input | 3 | Byte tag: 0 preamble, 1 start, 2 data, 3 end, 4..7 error |
| in_byte_i | input | 8 | Decoded byte |
| out_valid_o | output | 1 | Payload byte available |
| out_data_o | output | 8 | Payload byte |
| out_ready_i | input | 1 | Consumer accepts payload byte |
| receiving_o | output | 1 | Packet in flight; transmit must stay idle |
| eop_o | output | 1 | One-cycle end-of-packet pulse on idle gap |
| overflow_o | output | 1 | Sticky: payload byte lost to backpressure |

## Verification
Well-formed packets are swept over one to four preambles and zero to five payload bytes with arithmetic byte values. This separates correct stripping from off-by-one forwarding of the start delimiter or the last data byte. Malformed orderings exercise the hunt-state recovery paths: data before a delimiter, a start delimiter while idle, mid-packet errors and reserved tags. The gap timer is stepped one tick at a time so the 511th and 512th ticks are distinguished, and once more with a byte part-way through the gap to show the count restarts. Backpressure runs show hold, drop and the overflow clear.

// File: rtl/fb_rx_pkg.sv
package fb_rx_pkg;
  typedef enum logic [2:0] {
    TAG_PRE  = 3'd0,
    TAG_SD   = 3'd1,
    TAG_DATA = 3'd2,
    TAG_END  = 3'd3,
    TAG_ERR  = 3'd4
  } tag_e;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_PRE  = 2'd1,
    ST_PAY  = 2'd2
  } st_e;
endpackage

// File: rtl/fb_rx_framer.sv
module fb_rx_framer
  import fb_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_v_i,
  input  logic [2:0] tag_i,
  input  logic       timeout_i,
  output logic       receiving_o,
  output logic       push_o,
  output logic       start_o,
  output logic       arm_o
);
  st_e st_q, st_d;
  logic is_pre, is_sd, is_data;

  assign is_pre  = (tag_i == TAG_PRE);
  assign is_sd   = (tag_i == TAG_SD);
  assign is_data = (tag_i == TAG_DATA);

  always_comb begin
    st_d = st_q;
    if (byte_v_i) begin
      unique case (st_q)
        ST_HUNT: if (is_pre) st_d = ST_PRE;
        ST_PRE:  st_d = is_pre ? ST_PRE : (is_sd ? ST_PAY : ST_HUNT);
        ST_PAY:  st_d = is_data ? ST_PAY : ST_HUNT;
        default: st_d = ST_HUNT;
      endcase
    end else if (timeout_i) begin
      st_d = ST_HUNT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_HUNT;
    else         st_q <= st_d;
  end

  assign receiving_o = (st_q != ST_HUNT);
  assign push_o      = byte_v_i && is_data && (st_q == ST_PAY);
  assign start_o     = byte_v_i && is_pre && (st_q == ST_HUNT);
  assign arm_o       = byte_v_i && (is_pre || st_q != ST_HUNT);

  p_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> receiving_o);
  p_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_v_i && tag_i == TAG_END) |=> !receiving_o);
  p_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_v_i && tag_i >= TAG_ERR) |=> !receiving_o);
  p_push_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> receiving_o);
endmodule

// File: rtl/fb_gap_timer.sv
module fb_gap_timer #(
  parameter int GAP_US = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic byte_i,
  input  logic arm_i,
  output logic timeout_o,
  output logic eop_o
);
  localparam int CW = (GAP_US > 1) ? $clog2(GAP_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(GAP_US - 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  // a byte in the same cycle as a tick wins: no timeout
  assign timeout_o = tick_i && armed_q && !byte_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      eop_o   <= 1'b0;
    end else begin
      eop_o <= timeout_o;
      if (arm_i)          armed_q <= 1'b1;
      else if (timeout_o) armed_q <= 1'b0;
      if (byte_i)                    cnt_q <= '0;
      else if (tick_i && armed_q)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  p_eop_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> !eop_o);
  p_byte_no_eop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i |=> !eop_o);
  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/fb_skid_byte.sv
module fb_skid_byte #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         clr_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         ovf_o
);
  logic         full_q;
  logic [W-1:0] buf_q;
  logic         drop;

  assign drop = push_i && full_q && !ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      buf_q  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (push_i && !drop) begin
        full_q <= 1'b1;
        buf_q  <= data_i;
      end else if (full_q && ready_i) begin
        full_q <= 1'b0;
      end
      if (clr_i)     ovf_o <= 1'b0;
      else if (drop) ovf_o <= 1'b1;
    end
  end

  assign valid_o = full_q;
  assign data_o  = buf_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && valid_o && !ready_i && !clr_i) |=> ovf_o);
endmodule

// File: rtl/fb_rx_stripper.sv
module fb_rx_stripper #(
  parameter int GAP_US = 512,
  parameter int DW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          us_tick_i,
  input  logic          in_valid_i,
  input  logic [2:0]    in_tag_i,
  input  logic [DW-1:0] in_byte_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  input  logic          out_ready_i,
  output logic          receiving_o,
  output logic          eop_o,
  output logic          overflow_o
);
  logic push, start, arm, timeout;

  fb_rx_framer u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_v_i    (in_valid_i),
    .tag_i       (in_tag_i),
    .timeout_i   (timeout),
    .receiving_o (receiving_o),
    .push_o      (push),
    .start_o     (start),
    .arm_o       (arm)
  );

  fb_gap_timer #(.GAP_US(GAP_US)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (us_tick_i),
    .byte_i    (in_valid_i),
    .arm_i     (arm),
    .timeout_o (timeout),
    .eop_o     (eop_o)
  );

  fb_skid_byte #(.W(DW)) u_skid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (in_byte_i),
    .clr_i   (start),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .data_o  (out_data_o),
    .ovf_o   (overflow_o)
  );

  p_tx_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> !receiving_o);
endmodule

// File: tb/fb_rx_stripper_tb.sv
module fb_rx_stripper_tb;
  localparam int T_PRE = 0, T_SD = 1, T_DATA = 2, T_END = 3, T_ERR = 4;
  localparam int GAP = 512;

  logic       clk_i = 1'b0, rst_ni = 1'b0, us_tick_i = 1'b0;
  logic       in_valid_i = 1'b0, out_ready_i = 1'b1;
  logic [2:0] in_tag_i = '0;
  logic [7:0] in_byte_i = '0;
  logic       out_valid_o, receiving_o, eop_o, overflow_o;
  logic [7:0] out_data_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  fb_rx_stripper u_dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int tag, input int b);
    @(negedge clk_i);
    in_valid_i = 1'b1; in_tag_i = 3'(tag); in_byte_i = 8'(b);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk_i); us_tick_i = 1'b1;
    @(negedge clk_i); us_tick_i = 1'b0;
  endtask

  // returns number of eop pulses seen over n ticks
  task automatic ticks(input int n, output int eops);
    eops = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (eop_o) eops++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int e;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!out_valid_o && !receiving_o && !eop_o && !overflow_o, "R1 reset",
          {out_valid_o, receiving_o, eop_o, overflow_o}, 0);

    // R7: non-preamble tags while idle
    for (int t = 1; t < 8; t++) begin
      send(t, 8'hC0 + t);
      check(!receiving_o && !out_valid_o, "R7 idle ignore", {receiving_o, out_valid_o}, 0);
    end

    // R2/R3/R4 sweep
    for (int np = 1; np <= 4; np++) begin
      for (int nd = 0; nd <= 5; nd++) begin
        for (int p = 0; p < np; p++) begin
          send(T_PRE, 8'h55);
          check(receiving_o && !out_valid_o, "R2 preamble", {receiving_o, out_valid_o}, 2);
        end
        send(T_SD, 8'hE5);
        check(!out_valid_o && receiving_o, "R3 start stripped", out_valid_o, 0);
        for (int k = 0; k < nd; k++) begin
          int d = ((np * 37 + nd * 11 + k * 5) ^ 8'h5A) & 8'hFF;
          send(T_DATA, d);
          check(out_valid_o && out_data_o == 8'(d), "R3 payload", out_data_o, d);
        end
        send(T_END, 8'hAA);
        check(!receiving_o && !out_valid_o, "R4 end", {receiving_o, out_valid_o}, 0);
      end
    end

    // R4: preamble tag during payload ends packet
    send(T_PRE, 0); send(T_SD, 0); send(T_PRE, 0);
    check(!receiving_o && !out_valid_o, "R4 non-data in payload", receiving_o, 0);

    // R6: data before start delimiter
    send(T_PRE, 0); send(T_PRE, 0); send(T_DATA, 8'h12);
    check(!receiving_o && !out_valid_o, "R6 early data", {receiving_o, out_valid_o}, 0);
    send(T_SD, 0);
    check(!receiving_o, "R6 start while idle", receiving_o, 0);
    send(T_DATA, 8'h34);
    check(!out_valid_o, "R6 data after stray start", out_valid_o, 0);

    // R5: error aborts
    for (int t = T_ERR; t < 8; t++) begin
      send(T_PRE, 0); send(T_SD, 0); send(T_DATA, 8'h70 + t);
      check(out_valid_o && out_data_o == 8'(8'h70 + t), "R5 pre-error data", out_data_o, 8'h70 + t);
      send(t, 0);
      check(!receiving_o, "R5 error drop", receiving_o, 0);
      send(T_DATA, 8'h99);
      check(!out_valid_o, "R5 post-error data", out_valid_o, 0);
    end

    // R8: gap timeout while receiving
    send(T_PRE, 0); send(T_SD, 0); send(T_DATA, 8'h01);
    ticks(GAP - 1, e);
    check(e == 0 && receiving_o, "R8 before gap", e, 0);
    tick();
    check(eop_o && !receiving_o, "R8 eop at gap", {eop_o, receiving_o}, 2);
    @(negedge clk_i);
    check(!eop_o, "R8 single pulse", eop_o, 0);
    ticks(GAP, e);
    check(e == 0, "R8 no re-fire", e, 0);

    // R8: byte restarts count
    send(T_PRE, 0);
    ticks(300, e);
    send(T_PRE, 0);
    ticks(GAP - 1, e);
    check(e == 0 && receiving_o, "R8 restart", e, 0);
    tick();
    check(eop_o, "R8 eop after restart", eop_o, 1);

    // R8: eop after end delimiter
    send(T_PRE, 0); send(T_SD, 0); send(T_END, 0);
    ticks(GAP - 1, e);
    check(e == 0, "R8 after end early", e, 0);
    tick();
    check(eop_o, "R8 after end eop", eop_o, 1);

    // R9: backpressure and overflow
    out_ready_i = 1'b0;
    send(T_PRE, 0); send(T_SD, 0); send(T_DATA, 8'hA1);
    check(out_valid_o && out_data_o == 8'hA1 && !overflow_o, "R9 first held", out_data_o, 8'hA1);
    repeat (3) @(negedge clk_i);
    check(out_valid_o && out_data_o == 8'hA1, "R9 hold", out_data_o, 8'hA1);
    send(T_DATA, 8'hB2);
    check(overflow_o && out_data_o == 8'hA1, "R9 overflow", {overflow_o, out_data_o}, 9'h1A1);
    out_ready_i = 1'b1;
    @(negedge clk_i);
    check(!out_valid_o && overflow_o, "R9 drain sticky", {out_valid_o, overflow_o}, 1);
    send(T_END, 0);
    send(T_PRE, 0);
    check(!overflow_o, "R9 clear on new packet", overflow_o, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule